// File: doc/BRIEF.md
# Soft-Chopping Sign-Magnitude PWM

This block turns a signed control word into gate commands for the two legs of a full H-bridge. Only one leg is switched at a time. The leg on the side of the commanded direction is modulated, and the opposite leg stays low. Keeping the switching on one side at a time limits heating in the motor. The control word is an 8-bit two's-complement value. Its sign selects the leg, and its magnitude sets how many clock ticks of each fixed 128-tick period the modulated leg is driven high.

Each period starts by loading two cascaded down-counters at the same time. The pulse counter gets the magnitude, and the pause counter gets 128 minus the magnitude. The pulse interval runs first and the pause interval follows. When the pause interval ends, the next period loads straight away, so periods follow each other with no gap. The sign is captured at the same load and is held until the next one. A control change in the middle of a period therefore waits for the next boundary. The clock is intended to be about 1.8 MHz, which gives a switching rate of roughly 14 kHz.

Top module: `sm_softchop_pwm`

## Requirements
- R1: While reset is asserted, both leg outputs are low, whatever the enable and control inputs are.
- R2: Each period begins with the modulated leg high for exactly M consecutive clock cycles, where M is the magnitude of the control word.
- R3: Every period lasts exactly 128 cycles, with the pause interval lasting 128 − M cycles. The next period starts on the cycle right after the pause ends, with no idle cycle in between.
- R4: When bit 7 of the control word is 0, channel A (`drive_a`) carries the pulse and channel B (`drive_b`) stays low for the whole period.
- R5: When bit 7 of the control word is 1, channel B carries the pulse and channel A stays low for the whole period. The two outputs are never high together.
- R6: A negative control word has magnitude equal to its negation. The most negative value 0x80 gives M = 127, the same as full positive scale.
- R7: A control value of 0 gives no pulse, and both outputs stay low for the full 128-cycle period.
- R8: While enable is low, both outputs are low in that same cycle. On the first clock edge with enable high, a new period starts from the current control word.
- R9: The control word and its sign are sampled only at a period boundary. A change inside a period does not alter that period, and it takes effect in the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low forces both legs low and idles the counters |
| ctrl_val | input | 8 | Signed two's-complement control word |
| drive_a | output | 1 | Channel A leg command |
| drive_b | output | 1 | Channel B leg command |

## Verification
The hardest case to reach from the ports is a control change that lands inside a running period. The change has to be checked two ways: it must leave the rest of that period alone, and it must appear exactly one boundary later, possibly on the other leg. The stimulus starts a period from a known enable edge and switches the control word a few cycles in, including a switch across the sign. It then compares two back-to-back 128-cycle windows against widths computed in the bench. An exhaustive sweep over all 256 control words covers the most negative value and zero, and it checks the first cycle of the following period.

// File: rtl/sm_pwm_pkg.sv
package sm_pwm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PULSE = 2'd1,
      ST_PAUSE = 2'd2
   } chop_state_e;

   localparam int LEG_A = 0;
   localparam int LEG_B = 1;
endpackage

// File: rtl/sm_mag_extract.sv
module sm_mag_extract #(
   parameter int CTRL_W = 8,
   localparam int MAG_W = CTRL_W - 1
) (
   input  logic [CTRL_W-1:0] ctrl,
   output logic [MAG_W-1:0]  mag,
   output logic              neg
);
   logic [CTRL_W-1:0] negated;

   always_comb begin
      neg     = ctrl[CTRL_W-1];
      negated = ~ctrl + CTRL_W'(1);
      if (!neg) begin
         mag = ctrl[MAG_W-1:0];
      end else if (negated[CTRL_W-1]) begin
         // only the most negative word negates onto itself: clamp to full scale
         mag = '1;
      end else begin
         mag = negated[MAG_W-1:0];
      end
   end
endmodule

// File: rtl/sm_period_timer.sv
module sm_period_timer
   import sm_pwm_pkg::*;
#(
   parameter int MAG_W = 7,
   localparam int PERIOD = 1 << MAG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [MAG_W-1:0] mag,
   output logic             load,
   output logic             active
);
   localparam logic [MAG_W:0] PERIOD_V = PERIOD[MAG_W:0];

   chop_state_e      state;
   logic [MAG_W-1:0] pulse_cnt;
   logic [MAG_W:0]   pause_cnt;
   logic [MAG_W+1:0] cnt_sum;

   assign load   = enable && ((state == ST_IDLE) ||
                              (state == ST_PAUSE && pause_cnt == (MAG_W+1)'(1)));
   assign active = (state == ST_PULSE);
   assign cnt_sum = {2'b00, pulse_cnt} + {1'b0, pause_cnt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pulse_cnt <= '0;
         pause_cnt <= '0;
      end else if (!enable) begin
         state     <= ST_IDLE;
         pulse_cnt <= '0;
         pause_cnt <= '0;
      end else if (load) begin
         pulse_cnt <= mag;
         pause_cnt <= PERIOD_V - {1'b0, mag};
         state     <= (mag != '0) ? ST_PULSE : ST_PAUSE;
      end else begin
         case (state)
            ST_PULSE: begin
               pulse_cnt <= pulse_cnt - MAG_W'(1);
               if (pulse_cnt == MAG_W'(1)) state <= ST_PAUSE;
            end
            ST_PAUSE: pause_cnt <= pause_cnt - (MAG_W+1)'(1);
            default:  state <= ST_IDLE;
         endcase
      end
   end

   // R3: the two loads always add up to one full period
   assert_load_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_sum == PERIOD[MAG_W+1:0]));

   // R3: a pause interval never sits on an empty counter
   assert_pause_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PAUSE) |-> (pause_cnt != '0));

   // R2: the pulse interval is only entered with work left to do
   assert_pulse_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PULSE) |-> (pulse_cnt != '0));
endmodule

// File: rtl/sm_leg_steer.sv
module sm_leg_steer
   import sm_pwm_pkg::*;
#(
   parameter int LEGS = 2
) (
   input  logic            enable,
   input  logic            active,
   input  logic            sign_q,
   output logic [LEGS-1:0] legs
);
   for (genvar g = 0; g < LEGS; g++) begin : g_leg
      // leg A follows a positive sign, leg B a negative one
      logic dir_match;
      if (g == LEG_A) begin : g_pos
         assign dir_match = ~sign_q;
      end else begin : g_neg
         assign dir_match = sign_q;
      end
      assign legs[g] = enable & active & dir_match;
   end
endmodule

// File: rtl/sm_softchop_pwm.sv
module sm_softchop_pwm
   import sm_pwm_pkg::*;
#(
   parameter int CTRL_W = 8,
   localparam int MAG_W = CTRL_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [CTRL_W-1:0] ctrl_val,
   output logic              drive_a,
   output logic              drive_b
);
   if (CTRL_W < 3 || CTRL_W > 16) begin : g_bad_width
      $error("sm_softchop_pwm: CTRL_W must lie in 3..16");
   end

   logic [MAG_W-1:0] mag_w;
   logic             neg_w;
   logic             load_w;
   logic             active_w;
   logic             sign_q;
   logic [1:0]       legs_w;

   sm_mag_extract #(.CTRL_W(CTRL_W)) mag_i (
      .ctrl (ctrl_val),
      .mag  (mag_w),
      .neg  (neg_w)
   );

   sm_period_timer #(.MAG_W(MAG_W)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .mag    (mag_w),
      .load   (load_w),
      .active (active_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sign_q <= 1'b0;
      else if (load_w) sign_q <= neg_w;
   end

   sm_leg_steer #(.LEGS(2)) steer_i (
      .enable (enable),
      .active (active_w),
      .sign_q (sign_q),
      .legs   (legs_w)
   );

   assign drive_a = legs_w[LEG_A];
   assign drive_b = legs_w[LEG_B];

   // R5: soft chopping never drives both legs
   assert_legs_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(drive_a && drive_b));

   // R8: a disabled block keeps the bridge quiet
   assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!drive_a && !drive_b));

   // R9: the leg choice moves only at a period load
   assert_sign_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_w |=> $stable(sign_q));
endmodule

// File: tb/sm_softchop_pwm_tb_top.sv
module sm_softchop_pwm_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] ctrl = 8'h00;
   logic       drive_a;
   logic       drive_b;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sm_softchop_pwm #(.CTRL_W(8)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (en),
      .ctrl_val (ctrl),
      .drive_a  (drive_a),
      .drive_b  (drive_b)
   );

   function automatic int mag_of(input int v);
      if (v >= 0) return v;
      if (v == -128) return 127;
      return -v;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // start a fresh period with v1, optionally switch to v2 after sample chg
   task automatic run_case(input int v1, input int v2, input int chg,
                           input int ns, input string req);
      int mism = 0;
      int hi = 0;
      @(negedge clk); en = 1'b0;
      @(negedge clk); ctrl = v1[7:0]; en = 1'b1;
      for (int i = 0; i < ns; i++) begin
         int val, m, o;
         bit exp_a, exp_b;
         @(negedge clk); #1;
         val = (i >= 128) ? v2 : v1;
         m = mag_of(val);
         o = i % 128;
         exp_a = (val >= 0) && (o < m);
         exp_b = (val < 0) && (o < m);
         if (drive_a !== exp_a || drive_b !== exp_b) mism++;
         if (i < 128 && (drive_a || drive_b)) hi++;
         if (i == chg) ctrl = v2[7:0];
      end
      check(mism == 0, req, mism, 0);
      check(hi == mag_of(v1), "R2", hi, mag_of(v1));
   endtask

   initial begin
      string req;
      // R1: reset holds outputs low even with enable and a large command
      en = 1'b1; ctrl = 8'h40;
      repeat (5) @(negedge clk);
      #1;
      check(drive_a == 1'b0 && drive_b == 1'b0, "R1", {drive_a, drive_b}, 0);
      en = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      check(drive_a == 1'b0 && drive_b == 1'b0, "R8", {drive_a, drive_b}, 0);

      // exhaustive sweep, one period plus the first sample of the next (R3)
      for (int v = -128; v < 128; v++) begin
         if (v == 0) req = "R7";
         else if (v == -128) req = "R6";
         else if (v > 0) req = "R4";
         else req = "R5";
         run_case(v, v, 1000, 129, req);
      end

      // R3: three back-to-back periods with no gap
      run_case(5, 5, 1000, 384, "R3");
      run_case(-77, -77, 1000, 256, "R3");

      // R9: mid-period changes take effect only at the next boundary
      run_case(20, -30, 10, 256, "R9");
      run_case(-90, 60, 3, 256, "R9");
      run_case(0, 127, 64, 256, "R9");
      run_case(127, 0, 126, 256, "R9");

      // R8: dropping enable mid-pulse silences at once, re-enable restarts
      @(negedge clk); en = 1'b0;
      @(negedge clk); ctrl = 8'd100; en = 1'b1;
      repeat (5) @(negedge clk);
      #1;
      check(drive_a == 1'b1, "R8", drive_a, 1);
      en = 1'b0;
      #1;
      check(drive_a == 1'b0 && drive_b == 1'b0, "R8", {drive_a, drive_b}, 0);
      begin
         int seen = 0;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            if (drive_a || drive_b) seen++;
         end
         check(seen == 0, "R8", seen, 0);
      end
      run_case(3, 3, 1000, 129, "R8");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule